// File: doc/BRIEF.md
# Request Header Splitter for Bus-Mastering Transfers

The block takes one transfer command and turns it into a series of request header descriptors for a packet-based serial interconnect. A command gives a start byte address, a total byte count and one of four kinds: memory write, memory read, I/O write or I/O read. The block cuts the transfer into chunks. For each chunk it emits one descriptor carrying the format/type code, the requester ID, the chunk address, the length in dwords, the first and last byte enables, and a tag.

Memory chunks are limited in two ways. Each is capped by the negotiated size limit, less the start misalignment, and no chunk crosses a 4 KB page. I/O chunks never leave the dword they start in. Reads and I/O requests must take a tag from an external pool before they are issued, and the block waits while none is free. Commands are accepted on a valid/ready handshake. Descriptors leave on a second valid/ready handshake, one per beat.

The control is a three-state machine:
- ST_IDLE waits for a command. With a non-zero length, the transition "accept" moves to ST_GRAB. A zero-length command is accepted and the block stays in ST_IDLE.
- ST_GRAB moves to ST_ISSUE through "grant" once the chunk needs no tag or a tag is available.
- ST_ISSUE holds the descriptor. When it is taken, "advance" returns to ST_GRAB if bytes remain, and "finish" returns to ST_IDLE after the last chunk.

Top module: `tlp_req_splitter`

## Requirements
- R1: Out of reset the block is idle: cmd_ready is 1, and desc_valid and tag_take are 0.
- R2: The format/type code is fixed by the kind, which is encoded as 0 memory write, 1 memory read, 2 I/O write and 3 I/O read.
  - Memory write uses 0x40, or 0x60 when the chunk address is above 0xFFFFFFFF.
  - Memory read uses 0x00, or 0x20 when the chunk address is above 0xFFFFFFFF.
  - I/O write uses 0x42 and I/O read uses 0x02.
- R3: desc_req_id equals {cfg_bus[7:0], cfg_dev[4:0], 3'b000}.
- R4: A memory chunk is the smallest of three values: the remaining bytes, (128 << code) minus (address mod 4), and 0x1000 minus address[11:0]. The code is cfg_mps for writes and cfg_mrrs for reads.
- R5: An I/O chunk is the smaller of the remaining bytes and 4 minus (address mod 4).
- R6: Each accepted descriptor advances the address and reduces the remaining count by its chunk size. After the descriptor that completes the transfer, the block is idle again with cmd_ready at 1.
- R7: desc_dw_len equals ((address mod 4) + chunk + 3) / 4.
- R8: Bit i of a byte enable is byte i of that dword. The first byte enable clears the bytes below the start offset. The last byte enable clears the bytes past the chunk end. A one-dword chunk puts its whole mask in the first byte enable, and its last byte enable is 0.
- R9: Reads and I/O requests take tag_id with a one-cycle tag_take pulse, and tag_take is only asserted while tag_avail is 1. Memory writes never assert tag_take and carry desc_tag 0.
- R10: While no tag is available for a chunk that needs one, desc_valid stays 0.
- R11: While desc_valid is 1 and desc_ready is 0, the descriptor fields do not change.
- R12: A zero-length command is accepted and produces no descriptor.
- R13: cmd_ready is 0 while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mps | input | 3 | Max payload size code for writes |
| cfg_mrrs | input | 3 | Max read request size code for reads |
| cfg_bus | input | 8 | Bus number for the requester ID |
| cfg_dev | input | 5 | Device number for the requester ID |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Total byte count |
| cmd_kind | input | 2 | 0 mem write, 1 mem read, 2 I/O write, 3 I/O read |
| tag_avail | input | 1 | A free tag is offered |
| tag_id | input | TAG_W | Value of the offered tag |
| tag_take | output | 1 | Pulse taking the offered tag |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Descriptor consumed when high with desc_valid |
| desc_fmt_type | output | 8 | Format and type code |
| desc_req_id | output | 16 | Requester ID |
| desc_addr | output | ADDR_W | Chunk start byte address |
| desc_dw_len | output | 11 | Length in dwords |
| desc_first_be | output | 4 | First dword byte enables |
| desc_last_be | output | 4 | Last dword byte enables |
| desc_tag | output | TAG_W | Tag, 0 for memory writes |

## Verification
The assertions check the following on every cycle:
- a descriptor stays frozen under back-pressure;
- command acceptance and descriptor issue are exclusive;
- tags are only taken when one is offered, and each grant is followed by a descriptor;
- an I/O request is a single dword;
- the byte-enable shape agrees with the dword length.

Only the bench scenarios can show the actual chunk sizes. Those include the cuts at the page boundary and at the size limit, the switch to the 64-bit format when a transfer crosses 4 GB, and the exact byte enables. The scenarios also show that chunks add up to the full length, that the captured tags are carried through, and that zero-length commands and long tag starvation behave correctly.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        KIND_MWR  = 2'd0,
        KIND_MRD  = 2'd1,
        KIND_IOWR = 2'd2,
        KIND_IORD = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRAB  = 2'd1,
        ST_ISSUE = 2'd2
    } rs_state_e;

    localparam logic [7:0] FMT_MWR32 = 8'h40;
    localparam logic [7:0] FMT_MWR64 = 8'h60;
    localparam logic [7:0] FMT_MRD32 = 8'h00;
    localparam logic [7:0] FMT_MRD64 = 8'h20;
    localparam logic [7:0] FMT_IOWR  = 8'h42;
    localparam logic [7:0] FMT_IORD  = 8'h02;

    localparam int CHUNK_W = 13;   // a chunk never exceeds 4096 bytes
    localparam int DWLEN_W = 11;

endpackage

// File: rtl/rs_chunk_calc.sv
module rs_chunk_calc #(
    parameter int LEN_W = 16,
    parameter int CW    = 13
) (
    input  logic [11:0]      addr_lo,
    input  logic [LEN_W-1:0] remain,
    input  logic             is_io,
    input  logic [2:0]       size_code,
    output logic [CW-1:0]    chunk
);
    // wide enough for 128 << 7 and for the remaining count
    localparam int IW = (LEN_W > 16) ? LEN_W : 16;

    logic [IW-1:0] pad;
    logic [IW-1:0] max_bytes;
    logic [IW-1:0] lim_size;
    logic [IW-1:0] lim_page;
    logic [IW-1:0] rem_w;
    logic [IW-1:0] pick;

    always_comb begin
        pad       = IW'(addr_lo[1:0]);
        max_bytes = IW'(128) << size_code;
        lim_size  = max_bytes - pad;
        lim_page  = IW'(13'h1000 - {1'b0, addr_lo});
        rem_w     = IW'(remain);
        if (is_io) begin
            pick = (rem_w < (IW'(4) - pad)) ? rem_w : (IW'(4) - pad);
        end else begin
            pick = rem_w;
            if (lim_size < pick) pick = lim_size;
            if (lim_page < pick) pick = lim_page;
        end
        chunk = CW'(pick);
    end
endmodule

// File: rtl/rs_byte_en.sv
module rs_byte_en #(
    parameter int CW   = 13,
    parameter int DW_W = 11
) (
    input  logic [1:0]      pad,
    input  logic [CW-1:0]   chunk,
    output logic [DW_W-1:0] dw_len,
    output logic [3:0]      first_be,
    output logic [3:0]      last_be
);
    localparam int SW = CW + 1;

    logic [SW-1:0] span;
    logic [1:0]    tail_idx;
    logic [3:0]    lead_mask;
    logic [3:0]    tail_mask;

    always_comb begin
        span      = {1'b0, chunk} + SW'(pad);
        dw_len    = DW_W'((span + SW'(3)) >> 2);
        tail_idx  = span[1:0] - 2'd1;          // index of the final byte in its dword
        lead_mask = 4'hF << pad;
        tail_mask = 4'hF >> (2'd3 - tail_idx);
        if (dw_len == DW_W'(1)) begin
            first_be = lead_mask & tail_mask;
            last_be  = 4'h0;
        end else begin
            first_be = lead_mask;
            last_be  = tail_mask;
        end
    end
endmodule

// File: rtl/tlp_req_splitter.sv
module tlp_req_splitter
    import rs_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mps,
    input  logic [2:0]        cfg_mrrs,
    input  logic [7:0]        cfg_bus,
    input  logic [4:0]        cfg_dev,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [1:0]        cmd_kind,
    input  logic              tag_avail,
    input  logic [TAG_W-1:0]  tag_id,
    output logic              tag_take,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [7:0]        desc_fmt_type,
    output logic [15:0]       desc_req_id,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [10:0]       desc_dw_len,
    output logic [3:0]        desc_first_be,
    output logic [3:0]        desc_last_be,
    output logic [TAG_W-1:0]  desc_tag
);
    rs_state_e          state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   remain_q;
    req_kind_e          kind_q;
    logic [TAG_W-1:0]   tag_q;

    logic               is_io;
    logic               needs_tag;
    logic [2:0]         size_code;
    logic [CHUNK_W-1:0] chunk;
    logic [DWLEN_W-1:0] dw_len;
    logic [3:0]         fbe, lbe;
    logic               above_4g;
    logic               granted;
    logic               handoff;
    logic               final_chunk;

    assign is_io     = kind_q[1];
    assign needs_tag = (kind_q != KIND_MWR);
    assign size_code = (kind_q == KIND_MWR) ? cfg_mps : cfg_mrrs;

    rs_chunk_calc #(.LEN_W(LEN_W), .CW(CHUNK_W)) u_calc (
        .addr_lo   (addr_q[11:0]),
        .remain    (remain_q),
        .is_io     (is_io),
        .size_code (size_code),
        .chunk     (chunk)
    );

    rs_byte_en #(.CW(CHUNK_W), .DW_W(DWLEN_W)) u_be (
        .pad      (addr_q[1:0]),
        .chunk    (chunk),
        .dw_len   (dw_len),
        .first_be (fbe),
        .last_be  (lbe)
    );

    generate
        if (ADDR_W > 32) begin : g_wide
            assign above_4g = |addr_q[ADDR_W-1:32];
        end else begin : g_narrow
            assign above_4g = 1'b0;
        end
    endgenerate

    assign granted     = (state_q == ST_GRAB) && (!needs_tag || tag_avail);
    assign handoff     = (state_q == ST_ISSUE) && desc_ready;
    assign final_chunk = (remain_q == LEN_W'(chunk));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid && (cmd_len != '0)) state_d = ST_GRAB;    // accept
            ST_GRAB:  if (granted) state_d = ST_ISSUE;                        // grant
            ST_ISSUE: if (desc_ready) state_d = final_chunk ? ST_IDLE         // finish
                                                            : ST_GRAB;        // advance
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and per-transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            kind_q   <= KIND_MWR;
            tag_q    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && cmd_valid) begin
                addr_q   <= cmd_addr;
                remain_q <= cmd_len;
                kind_q   <= req_kind_e'(cmd_kind);
            end
            if (granted) begin
                tag_q <= needs_tag ? tag_id : '0;
            end
            if (handoff) begin
                addr_q   <= addr_q + ADDR_W'(chunk);
                remain_q <= remain_q - LEN_W'(chunk);
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready     = (state_q == ST_IDLE);
        desc_valid    = (state_q == ST_ISSUE);
        tag_take      = granted && needs_tag;
        desc_req_id   = {cfg_bus, cfg_dev, 3'b000};
        desc_addr     = addr_q;
        desc_dw_len   = dw_len;
        desc_first_be = fbe;
        desc_last_be  = lbe;
        desc_tag      = tag_q;
        unique case (kind_q)
            KIND_MWR:  desc_fmt_type = above_4g ? FMT_MWR64 : FMT_MWR32;
            KIND_MRD:  desc_fmt_type = above_4g ? FMT_MRD64 : FMT_MRD32;
            KIND_IOWR: desc_fmt_type = FMT_IOWR;
            KIND_IORD: desc_fmt_type = FMT_IORD;
            default:   desc_fmt_type = FMT_MWR32;
        endcase
    end
endmodule

// File: rtl/rs_splitter_chk.sv
module rs_splitter_chk #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16,
    parameter int TAG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              tag_avail,
    input logic              tag_take,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [7:0]        desc_fmt_type,
    input logic [ADDR_W-1:0] desc_addr,
    input logic [10:0]       desc_dw_len,
    input logic [3:0]        desc_first_be,
    input logic [3:0]        desc_last_be,
    input logic [TAG_W-1:0]  desc_tag
);
    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_addr)
            && $stable(desc_dw_len) && $stable(desc_first_be)
            && $stable(desc_last_be) && $stable(desc_tag) && $stable(desc_fmt_type)));

    // R13
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> !cmd_ready);

    // R9
    tag_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_take |-> tag_avail);

    // R10
    grant_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_take |=> desc_valid);

    // R5
    io_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && ((desc_fmt_type == 8'h42) || (desc_fmt_type == 8'h02)))
            |-> (desc_dw_len == 11'd1));

    // R8
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && (desc_dw_len == 11'd1)) |-> (desc_last_be == 4'h0 && desc_first_be != 4'h0));

    // R8
    be_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && (desc_dw_len > 11'd1)) |-> (desc_last_be[0] && desc_first_be[3]));

    // R7
    dw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_dw_len != 11'd0 && desc_dw_len <= 11'd1024));
endmodule

bind tlp_req_splitter rs_splitter_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_tlp_req_splitter.sv
`timescale 1ns/1ps
module sim_tlp_req_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mps = 3'd0, cfg_mrrs = 3'd0;
    logic [7:0]  cfg_bus = 8'h00;
    logic [4:0]  cfg_dev = 5'h00;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic [1:0]  cmd_kind = '0;
    logic        tag_avail = 1'b1;
    logic [7:0]  tag_id = '0;
    logic        tag_take;
    logic        desc_valid;
    logic        desc_ready = 1'b0;
    logic [7:0]  desc_fmt_type;
    logic [15:0] desc_req_id;
    logic [63:0] desc_addr;
    logic [10:0] desc_dw_len;
    logic [3:0]  desc_first_be, desc_last_be;
    logic [7:0]  desc_tag;

    int checks = 0;
    int errors = 0;
    logic [7:0] next_tag = 8'h10;

    always #2.5 clk = ~clk;   // 200 MHz

    tlp_req_splitter u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned ref_chunk(logic [63:0] a, int unsigned rem, int kind,
                                              int mps, int mrrs);
        int unsigned pad = int'(a[1:0]);
        int unsigned lim;
        int unsigned page;
        int unsigned r = rem;
        if (kind >= 2) return (r < 4 - pad) ? r : 4 - pad;
        lim  = (128 << ((kind == 0) ? mps : mrrs)) - pad;
        page = 4096 - int'(a[11:0]);
        if (lim < r) r = lim;
        if (page < r) r = page;
        return r;
    endfunction

    function automatic logic [7:0] ref_fmt(logic [63:0] a, int kind);
        bit hi = (a > 64'hFFFF_FFFF);
        case (kind)
            0: return hi ? 8'h60 : 8'h40;
            1: return hi ? 8'h20 : 8'h00;
            2: return 8'h42;
            default: return 8'h02;
        endcase
    endfunction

    task automatic run_cmd(input logic [63:0] a, input int unsigned len, input int kind,
                           input int starve_in);
        logic [63:0] ea = a;
        int unsigned rem = len;
        int unsigned ck, pad, dw, fin;
        logic [3:0] efb, elb;
        logic [7:0] taken = '0;
        bit hold = 0;
        logic [63:0] h_addr = '0;
        logic [10:0] h_dw = '0;
        logic [7:0]  h_tag = '0;
        int starve = starve_in;
        bit starving;
        int guard = 0;
        cmd_addr  = a;
        cmd_len   = len[15:0];
        cmd_kind  = kind[1:0];
        cmd_valid = 1'b1;
        #1;
        chk(cmd_ready == 1'b1, "R13", "idle before command", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (len == 0) begin
            chk(cmd_ready && !desc_valid, "R12", "zero length idle", 64'(desc_valid), 64'd0);
            repeat (3) begin
                @(negedge clk);
                chk(!desc_valid, "R12", "zero length no descriptor", 64'(desc_valid), 64'd0);
            end
            return;
        end
        while (rem > 0) begin
            tag_id     = next_tag;
            desc_ready = ($urandom % 4) != 0;
            starving   = (starve > 0);
            if (starving) begin
                tag_avail = 1'b0;
                starve--;
            end else begin
                tag_avail = ($urandom % 3) != 0;
            end
            #1;
            if (hold) begin
                chk(desc_valid && desc_addr == h_addr && desc_dw_len == h_dw && desc_tag == h_tag,
                    "R11", "held descriptor", desc_addr, h_addr);
            end
            if (starving && kind != 0 && rem == len)
                chk(!desc_valid, "R10", "valid during tag starvation", 64'(desc_valid), 64'd0);
            if (kind == 0)
                chk(!tag_take, "R9", "write takes no tag", 64'(tag_take), 64'd0);
            if (tag_take) begin
                taken    = tag_id;
                next_tag = tag_id + 8'd1;
            end
            if (desc_valid)
                chk(!cmd_ready, "R13", "busy blocks commands", 64'(cmd_ready), 64'd0);
            hold   = desc_valid && !desc_ready;
            h_addr = desc_addr;
            h_dw   = desc_dw_len;
            h_tag  = desc_tag;
            if (desc_valid && desc_ready) begin
                ck  = ref_chunk(ea, rem, kind, int'(cfg_mps), int'(cfg_mrrs));
                pad = int'(ea[1:0]);
                dw  = (pad + ck + 3) / 4;
                fin = pad + ck;                 // byte offset past the end, from dword 0
                efb = '0;
                elb = '0;
                for (int i = 0; i < 4; i++) begin
                    if (i >= pad && i < fin) efb[i] = 1'b1;
                    if (dw > 1 && ((dw - 1) * 4 + i) < fin) elb[i] = 1'b1;
                end
                chk(desc_fmt_type == ref_fmt(ea, kind), "R2", "fmt type", 64'(desc_fmt_type), 64'(ref_fmt(ea, kind)));
                chk(desc_req_id == {cfg_bus, cfg_dev, 3'b000}, "R3", "requester id", 64'(desc_req_id), 64'({cfg_bus, cfg_dev, 3'b000}));
                chk(desc_addr == ea, "R6", "chunk address", desc_addr, ea);
                chk(desc_dw_len == 11'(dw), kind >= 2 ? "R5" : "R4", "dword length", 64'(desc_dw_len), 64'(dw));
                chk(desc_dw_len == 11'(dw), "R7", "dword length", 64'(desc_dw_len), 64'(dw));
                chk(desc_first_be == efb, "R8", "first be", 64'(desc_first_be), 64'(efb));
                chk(desc_last_be == elb, "R8", "last be", 64'(desc_last_be), 64'(elb));
                chk(desc_tag == ((kind == 0) ? 8'h00 : taken), "R9", "tag", 64'(desc_tag), 64'((kind == 0) ? 8'h00 : taken));
                ea  = ea + 64'(ck);
                rem = rem - ck;
                hold = 0;
            end
            @(negedge clk);
            guard++;
            if (guard > 20000) begin
                chk(0, "R6", "transfer did not finish", 64'(rem), 64'd0);
                return;
            end
        end
        #1;
        chk(cmd_ready && !desc_valid, "R6", "idle after final chunk", 64'(cmd_ready), 64'd1);
        desc_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        #1;
        // R1
        chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", 64'(cmd_ready), 64'd1);
        chk(desc_valid == 1'b0, "R1", "reset desc_valid", 64'(desc_valid), 64'd0);
        chk(tag_take == 1'b0, "R1", "reset tag_take", 64'(tag_take), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_bus = 8'h3C;
        cfg_dev = 5'h15;
        cfg_mps = 3'd0;
        cfg_mrrs = 3'd2;
        run_cmd(64'h0000_0FF3, 200, 0, 0);        // R4 page cut with misalignment
        run_cmd(64'hFFFF_FFF0, 40, 0, 0);         // R2 crossing into 64-bit space
        run_cmd(64'h0000_0002_0000_0101, 900, 1, 0);  // R4 read size code
        run_cmd(64'h0000_1001, 7, 2, 0);          // R5 I/O write
        run_cmd(64'h0000_2003, 9, 3, 12);         // R5 R10 I/O read with starvation
        run_cmd(64'h0000_5000, 0, 1, 0);          // R12
        run_cmd(64'h0000_3002, 1, 0, 0);          // R8 single byte
        run_cmd(64'h0000_7FFE, 3000, 1, 20);      // R10 long starvation, R4 page cut

        for (int n = 0; n < 150; n++) begin
            int k = int'($urandom % 4);
            int unsigned len;
            logic [63:0] a;
            cfg_mps  = 3'($urandom % 6);
            cfg_mrrs = 3'($urandom % 6);
            cfg_bus  = 8'($urandom);
            cfg_dev  = 5'($urandom);
            case ($urandom % 3)
                0: a = {32'h0, 32'($urandom)};
                1: a = {32'($urandom % 7 + 1), 32'($urandom)};
                default: a = {32'h0, 20'($urandom), 12'hFF0 + 12'($urandom % 16)};
            endcase
            if (k >= 2) begin
                a   = {32'h0, a[31:0]};
                len = 1 + ($urandom % 12);
            end else begin
                len = 1 + ($urandom % 2500);
            end
            if (($urandom % 20) == 0) len = 0;
            run_cmd(a, len, k, (($urandom % 5) == 0) ? 6 : 0);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule